// File: doc/BRIEF.md
# Frame-Sequence Phase Resync

This block tracks output video frames and flags the first frame of the repeating multi-frame cadence that audio and video share at fractional frame rates. The cadence is 5 frames long at the 30 (or 29.97) frames-per-second rate and 10 frames long at the 60 (or 59.94) rate. A counter advances on every line-1 horizontal-sync leading-edge strobe. A sequence-marker output is high for the whole frame in which the count is zero.

An external frame-identifier input is looked at only on the line-1 strobe cycle. When it is high there, the counter is pulled back to the start of the sequence, and single-cycle reset strobes go out in the same cycle:
- one to the frame-identifier output divider;
- one to the audio clock phase dividers;
- one to the audio frame-sync divider, unless a control bit removes that coupling.

With the identifier input tied low, the counter runs free and no strobe is ever issued.

Top module: `fsr_resync`

## Requirements
- R1: While reset is high, and after reset until the first line-1 strobe, seq_mark, fid_div_rst, afs_div_rst and aclk_phase_rst are all 0.
- R2: The first line-1 strobe after reset loads count 0. seq_mark is high from the clock edge that takes that strobe until the edge that takes the next strobe.
- R3: With rate_sel = 0 and fid_in low, the count steps 0,1,2,3,4,0,... on successive strobes. seq_mark is high exactly when the count is 0, so it is high on every 5th frame.
- R4: With rate_sel = 1 and fid_in low, the count wraps after 10 frames. seq_mark is high on every 10th frame.
- R5: fid_in high on a line-1 strobe cycle loads count 0 at that edge, instead of incrementing, whatever the current count is.
- R6: fid_div_rst is high for exactly the cycles in which line1_stb and fid_in are both high, and in no other cycle.
- R7: aclk_phase_rst is high for exactly the cycles in which line1_stb and fid_in are both high.
- R8: With afs_couple_en = 1, afs_div_rst equals fid_div_rst in every cycle.
- R9: With afs_couple_en = 0, afs_div_rst stays 0, while fid_div_rst and aclk_phase_rst still fire.
- R10: fid_in high outside a strobe cycle has no effect: no strobe is issued, and the count (seen on seq_mark over the following frames) is unchanged.
- R11: A change of rate_sel forces count 0 at the next clock edge. Once the sequence has started, seq_mark is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line1_stb | input | 1 | One-cycle strobe at the line-1 HSYNC leading edge |
| fid_in | input | 1 | External frame-identifier input |
| rate_sel | input | 1 | 0: 5-frame sequence, 1: 10-frame sequence |
| afs_couple_en | input | 1 | 1: identifier event also resets the audio frame-sync divider |
| seq_mark | output | 1 | High during the frame whose sequence count is 0 |
| fid_div_rst | output | 1 | Reset strobe to the frame-identifier divider |
| afs_div_rst | output | 1 | Reset strobe to the audio frame-sync divider |
| aclk_phase_rst | output | 1 | Phase reset strobe to the audio clock dividers |

## Verification
The bench uses the default lengths of 5 and 10 frames. Both wrap points, and resync at every count position of both cadences, can then be swept in full within a few thousand cycles. Identifier pulses on and off the strobe cycle are tried with the coupling bit in both states. Rate changes are made mid-sequence, which brings the forced-zero path into view.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    typedef enum logic {
        RATE_STD    = 1'b0,
        RATE_DOUBLE = 1'b1
    } fsr_rate_e;

    typedef struct packed {
        logic fid_div;
        logic afs_div;
        logic aclk_phase;
    } fsr_strobe_t;
endpackage

// File: rtl/fsr_len_sel.sv
module fsr_len_sel
    import fsr_pkg::*;
#(
    parameter int SEQ_LEN_LO = 5,
    parameter int SEQ_LEN_HI = 10,
    parameter int CNT_W      = 4
) (
    input  logic             rate_sel,
    output logic [CNT_W-1:0] last_cnt
);
    localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(SEQ_LEN_LO - 1);
    localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(SEQ_LEN_HI - 1);

    always_comb begin
        if (fsr_rate_e'(rate_sel) == RATE_DOUBLE) begin
            last_cnt = LAST_HI;
        end else begin
            last_cnt = LAST_LO;
        end
    end
endmodule

// File: rtl/fsr_frame_ctr.sv
module fsr_frame_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line1_stb,
    input  logic             fid_in,
    input  logic             rate_sel,
    input  logic [CNT_W-1:0] last_cnt,
    output logic             seq_mark
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             started;
        logic             rate;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rate = rate_sel;
        if (rate_sel != st_q.rate) begin
            st_d.cnt = '0;
        end else if (line1_stb) begin
            if (fid_in || !st_q.started || st_q.cnt >= last_cnt) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (line1_stb) begin
            st_d.started = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt     <= '0;
            st_q.started <= 1'b0;
            st_q.rate    <= rate_sel;
        end else begin
            st_q <= st_d;
        end
    end

    assign seq_mark = st_q.started && (st_q.cnt == '0);
endmodule

// File: rtl/fsr_strobe_gen.sv
module fsr_strobe_gen
    import fsr_pkg::*;
(
    input  logic        rst,
    input  logic        line1_stb,
    input  logic        fid_in,
    input  logic        afs_couple_en,
    output fsr_strobe_t stb_o
);
    logic hit;

    always_comb begin
        hit              = line1_stb && fid_in && !rst;
        stb_o.fid_div    = hit;
        stb_o.aclk_phase = hit;
        stb_o.afs_div    = hit && afs_couple_en;
    end
endmodule

// File: rtl/fsr_resync.sv
module fsr_resync
    import fsr_pkg::*;
#(
    parameter int SEQ_LEN_LO = 5,
    parameter int SEQ_LEN_HI = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic line1_stb,
    input  logic fid_in,
    input  logic rate_sel,
    input  logic afs_couple_en,
    output logic seq_mark,
    output logic fid_div_rst,
    output logic afs_div_rst,
    output logic aclk_phase_rst
);
    localparam int SEQ_MAX = (SEQ_LEN_HI > SEQ_LEN_LO) ? SEQ_LEN_HI : SEQ_LEN_LO;
    localparam int CNT_W   = (SEQ_MAX > 2) ? $clog2(SEQ_MAX) : 1;

    logic [CNT_W-1:0] last_cnt;
    fsr_strobe_t      stb;

    fsr_len_sel #(
        .SEQ_LEN_LO(SEQ_LEN_LO),
        .SEQ_LEN_HI(SEQ_LEN_HI),
        .CNT_W     (CNT_W)
    ) len_i (
        .rate_sel(rate_sel),
        .last_cnt(last_cnt)
    );

    fsr_frame_ctr #(
        .CNT_W(CNT_W)
    ) ctr_i (
        .clk      (clk),
        .rst      (rst),
        .line1_stb(line1_stb),
        .fid_in   (fid_in),
        .rate_sel (rate_sel),
        .last_cnt (last_cnt),
        .seq_mark (seq_mark)
    );

    fsr_strobe_gen stb_i (
        .rst          (rst),
        .line1_stb    (line1_stb),
        .fid_in       (fid_in),
        .afs_couple_en(afs_couple_en),
        .stb_o        (stb)
    );

    assign fid_div_rst    = stb.fid_div;
    assign afs_div_rst    = stb.afs_div;
    assign aclk_phase_rst = stb.aclk_phase;
endmodule

// File: rtl/fsr_resync_chk.sv
module fsr_resync_chk (
    input logic clk,
    input logic rst,
    input logic line1_stb,
    input logic fid_in,
    input logic rate_sel,
    input logic afs_couple_en,
    input logic seq_mark,
    input logic fid_div_rst,
    input logic afs_div_rst,
    input logic aclk_phase_rst
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |-> !fid_div_rst && !afs_div_rst && !aclk_phase_rst);

    // R1
    reset_mark_chk: assert property (@(posedge clk)
        rst |=> !seq_mark);

    // R6
    fid_strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        fid_div_rst |-> line1_stb && fid_in);

    // R6
    fid_strobe_fire_chk: assert property (@(posedge clk) disable iff (rst)
        line1_stb && fid_in |-> fid_div_rst);

    // R7
    aclk_match_chk: assert property (@(posedge clk) disable iff (rst)
        aclk_phase_rst == fid_div_rst);

    // R8
    afs_follow_chk: assert property (@(posedge clk) disable iff (rst)
        afs_couple_en |-> afs_div_rst == fid_div_rst);

    // R9
    afs_block_chk: assert property (@(posedge clk) disable iff (rst)
        !afs_couple_en |-> !afs_div_rst);

    // R5
    resync_mark_chk: assert property (@(posedge clk) disable iff (rst)
        line1_stb && fid_in |=> seq_mark);

    // R10
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !line1_stb && rate_sel == $past(rate_sel) |=> $stable(seq_mark));
endmodule

bind fsr_resync fsr_resync_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .line1_stb     (line1_stb),
    .fid_in        (fid_in),
    .rate_sel      (rate_sel),
    .afs_couple_en (afs_couple_en),
    .seq_mark      (seq_mark),
    .fid_div_rst   (fid_div_rst),
    .afs_div_rst   (afs_div_rst),
    .aclk_phase_rst(aclk_phase_rst)
);

// File: tb/fsr_resync_tb_top.sv
module fsr_resync_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_LO     = 5;
    localparam int LEN_HI     = 10;

    logic clk = 1'b0;
    logic rst, line1_stb, fid_in, rate_sel, afs_couple_en;
    logic seq_mark, fid_div_rst, afs_div_rst, aclk_phase_rst;

    int n_chk = 0;
    int n_err = 0;

    // bench model of the sequence
    int m_cnt     = 0;
    bit m_started = 0;
    bit m_rate    = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fsr_resync #(.SEQ_LEN_LO(LEN_LO), .SEQ_LEN_HI(LEN_HI)) dut_i (
        .clk(clk), .rst(rst), .line1_stb(line1_stb), .fid_in(fid_in),
        .rate_sel(rate_sel), .afs_couple_en(afs_couple_en),
        .seq_mark(seq_mark), .fid_div_rst(fid_div_rst),
        .afs_div_rst(afs_div_rst), .aclk_phase_rst(aclk_phase_rst)
    );

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // one clock cycle; entered and left at a falling edge
    task automatic cyc(bit r, bit stb, bit fid, bit rate, bit cpl, string tag);
        bit hit;
        int len;
        rst = r; line1_stb = stb; fid_in = fid; rate_sel = rate; afs_couple_en = cpl;
        #1;
        hit = !r && stb && fid;
        check(tag, "seq_mark", int'(seq_mark), int'(m_started && m_cnt == 0));
        check("R6", "fid_div_rst", int'(fid_div_rst), int'(hit));
        check("R7", "aclk_phase_rst", int'(aclk_phase_rst), int'(hit));
        if (cpl) check("R8", "afs_div_rst", int'(afs_div_rst), int'(hit));
        else     check("R9", "afs_div_rst", int'(afs_div_rst), 0);
        @(posedge clk);
        len = m_rate ? LEN_HI : LEN_LO;
        if (r) begin
            m_cnt = 0; m_started = 0;
        end else begin
            if (rate != m_rate) m_cnt = 0;
            else if (stb) m_cnt = (fid || !m_started) ? 0 : (m_cnt + 1) % len;
            if (stb) m_started = 1;
        end
        m_rate = rate;
        @(negedge clk);
    endtask

    task automatic do_reset(bit rate, bit cpl);
        cyc(1, 0, 0, rate, cpl, "R1");
        cyc(1, 1, 1, rate, cpl, "R1");
        cyc(0, 0, 0, rate, cpl, "R1");
        cyc(0, 0, 1, rate, cpl, "R1");
    endtask

    // one frame: strobe then a few idle cycles, fid optionally toggled in idle
    task automatic frame(bit fid, bit rate, bit cpl, bit idle_fid, string tag);
        cyc(0, 1, fid, rate, cpl, tag);
        cyc(0, 0, idle_fid, rate, cpl, idle_fid ? "R10" : tag);
        cyc(0, 0, 0, rate, cpl, tag);
    endtask

    initial begin
        @(negedge clk);
        for (int r = 0; r < 2; r++) begin
            do_reset(r[0], 1);
            frame(0, r[0], 1, 0, "R2");
            for (int f = 0; f < 3 * (r ? LEN_HI : LEN_LO) + 2; f++)
                frame(0, r[0], f[0], f[1], r ? "R4" : "R3");
            // resync from every count position, coupling both ways
            for (int cpl = 0; cpl < 2; cpl++) begin
                for (int p = 0; p < (r ? LEN_HI : LEN_LO); p++) begin
                    for (int k = 0; k < p; k++) frame(0, r[0], cpl[0], 1, "R10");
                    frame(1, r[0], cpl[0], 0, "R5");
                    frame(0, r[0], cpl[0], 0, "R5");
                end
            end
        end
        // rate change mid-sequence
        do_reset(0, 1);
        for (int p = 1; p < LEN_LO; p++) begin
            for (int k = 0; k < p + 1; k++) frame(0, 0, 1, 0, "R3");
            cyc(0, 0, 0, 1, 1, "R11");
            cyc(0, 0, 0, 1, 1, "R11");
            for (int k = 0; k < p + 2; k++) frame(0, 1, 1, 0, "R4");
            cyc(0, 0, 0, 0, 1, "R11");
            cyc(0, 0, 0, 0, 1, "R11");
        end
        // rate change together with a strobe
        frame(0, 0, 0, 0, "R3");
        cyc(0, 1, 0, 1, 0, "R11");
        cyc(0, 0, 0, 1, 0, "R11");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: run did not finish actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule